// File: doc/BRIEF.md
# Two-way cache lookup with virtual index and physical tag confirmation

This block is the read-lookup stage of a first-level data cache. A load presents only its untranslated low address bits. They sit inside the page offset, so the block can pick a set and read both ways' tags and the addressed word at once. At the same moment the page number goes to an external TLB. The TLB's answer arrives on a separate input one or more cycles later. The block compares the translated physical page number with the physical tags it read, and only then releases the word. If neither way matches, the block asks for the whole line on a fill port, installs the line, and answers from the fill data.

A translation fault ends the lookup with an error response and no fill. The block handles one request at a time. It accepts a new load only when it is idle.

Top module: `vipt_lookup`

## Requirements
- R1: After reset every line is invalid, every replacement bit is 0, `req_ready` is 1, and `resp_valid` and `fill_req` are 0.
- R2: A load is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the block is idle. The word address splits as set = `req_vwaddr[WSEL_W+IDX_W-1:WSEL_W]` and word-in-line = `req_vwaddr[WSEL_W-1:0]`.
- R3: From the cycle after acceptance, the TLB inputs are sampled on every edge. While `tlb_valid` is 0 the block stalls: no response is given and no fill is requested.
- R4: On the edge where `tlb_valid`=1 and `tlb_fault`=0, suppose a valid way of the set holds a tag equal to `tlb_ppn`. Then in the next cycle `resp_valid`=1, `resp_err`=0, `resp_miss`=0, and `resp_data` is the addressed word of that way. At most one way ever matches.
- R5: On the edge where `tlb_valid`=1 and `tlb_fault`=1, the next cycle gives `resp_valid`=1, `resp_err`=1, `resp_miss`=0 and `resp_data`=0. No fill is requested and no line or replacement bit changes.
- R6: If no valid way matches, then from the next cycle `fill_req`=1 and `fill_line`={`tlb_ppn`, set}. Both hold steady until `fill_valid` is seen.
- R7: On the edge where `fill_valid`=1 during a fill, the line is installed in the victim way with tag `tlb_ppn`. The next cycle gives `resp_valid`=1, `resp_miss`=1, `resp_err`=0, and `resp_data` = word w of `fill_data`, which is bits [32w+31:32w] when DW=32.
- R8: Each set has one replacement bit that names the way the next fill evicts. A hit on way w sets the bit to the other way, and so does a fill into way w.
- R9: `resp_valid` is a single-cycle pulse per accepted load.
- R10: `tlb_valid` while idle and `fill_valid` outside a fill are ignored. They cause no response, no fill request and no change to stored lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request |
| req_ready | output | 1 | Block is idle and can accept a load |
| req_vwaddr | input | IDX_W+WSEL_W | Untranslated word address (set and word-in-line) |
| tlb_valid | input | 1 | Translation result present |
| tlb_fault | input | 1 | Translation faulted |
| tlb_ppn | input | PPN_W | Translated physical page number |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 1 | Response is a translation fault |
| resp_miss | output | 1 | Response was served by a line fill |
| resp_data | output | DW | Returned word |
| fill_req | output | 1 | Line fill requested |
| fill_line | output | PPN_W+IDX_W | Physical line address of the fill |
| fill_valid | input | 1 | Fill line delivered |
| fill_data | input | LINE_WORDS*DW | Fill line, word 0 in the low bits |

## Verification
Suppose a tag, valid bit or replacement bit is wrong inside the block. A bad tag or valid bit shows up at the ports on the very next access to that set: the access reports a miss where a hit is due, or the reverse. A bad replacement bit shows up only when a later third page is filled into the set and evicts the wrong line. The next access to the surviving page then misses, often several accesses after the fault. A wrong stall or confirmation path shows up within one cycle of the TLB answer, as a response that comes early, comes twice, or never comes.

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int PPN_W      = 20,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int DW         = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LINE_W    = LINE_WORDS * DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W+WSEL_W-1:0] req_vwaddr,
  input  logic                   tlb_valid,
  input  logic                   tlb_fault,
  input  logic [PPN_W-1:0]       tlb_ppn,
  output logic                   resp_valid,
  output logic                   resp_err,
  output logic                   resp_miss,
  output logic [DW-1:0]          resp_data,
  output logic                   fill_req,
  output logic [PPN_W+IDX_W-1:0] fill_line,
  input  logic                   fill_valid,
  input  logic [LINE_W-1:0]      fill_data
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} state_t;
  state_t state;

  logic [PPN_W-1:0]  tag_q  [2][SETS];
  logic [LINE_W-1:0] line_q [2][SETS];
  logic [SETS-1:0]   val_q  [2];
  logic [SETS-1:0]   lru_q;

  logic [IDX_W-1:0]  set_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [PPN_W-1:0]  rd_tag  [2];
  logic [DW-1:0]     rd_word [2];
  logic [1:0]        rd_val;
  logic [PPN_W-1:0]  ppn_q;
  logic              victim_q;

  wire accept = req_valid && req_ready;
  wire [IDX_W-1:0]  set_in  = req_vwaddr[WSEL_W +: IDX_W];
  wire [WSEL_W-1:0] wsel_in = req_vwaddr[WSEL_W-1:0];

  logic [1:0] hit_vec;
  always_comb
    for (int w = 0; w < 2; w++)
      hit_vec[w] = rd_val[w] && (rd_tag[w] == tlb_ppn);

  wire any_hit = |hit_vec;
  wire hit_way = hit_vec[1];
  wire look_done = (state == S_LOOK) && tlb_valid;
  wire fill_done = (state == S_FILL) && fill_valid;

  assign req_ready = (state == S_IDLE);
  assign fill_req  = (state == S_FILL);
  assign fill_line = {ppn_q, set_q};

  // Array read launched at acceptance, in parallel with translation
  always_ff @(posedge clk) begin
    if (accept) begin
      set_q  <= set_in;
      wsel_q <= wsel_in;
      for (int w = 0; w < 2; w++) begin
        rd_tag[w]  <= tag_q[w][set_in];
        rd_val[w]  <= val_q[w][set_in];
        rd_word[w] <= line_q[w][set_in][wsel_in*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (look_done && !tlb_fault && !any_hit) begin
      ppn_q    <= tlb_ppn;
      victim_q <= lru_q[set_q];
    end
    if (fill_done) begin
      line_q[victim_q][set_q] <= fill_data;
      tag_q[victim_q][set_q]  <= ppn_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      val_q[0]   <= '0;
      val_q[1]   <= '0;
      lru_q      <= '0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) state <= S_LOOK;
        S_LOOK: if (tlb_valid) begin
          if (tlb_fault) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            resp_miss  <= 1'b0;
            resp_data  <= '0;
            state      <= S_IDLE;
          end else if (any_hit) begin
            resp_valid   <= 1'b1;
            resp_err     <= 1'b0;
            resp_miss    <= 1'b0;
            resp_data    <= rd_word[hit_way];
            lru_q[set_q] <= ~hit_way;
            state        <= S_IDLE;
          end else begin
            state <= S_FILL;
          end
        end
        S_FILL: if (fill_valid) begin
          val_q[victim_q][set_q] <= 1'b1;
          lru_q[set_q]           <= ~victim_q;
          resp_valid             <= 1'b1;
          resp_err               <= 1'b0;
          resp_miss              <= 1'b1;
          resp_data              <= fill_data[wsel_q*DW +: DW];
          state                  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_no_unconfirmed_data: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(state) == S_LOOK && $past(tlb_valid)) ||
                   ($past(state) == S_FILL && $past(fill_valid)));

  a_r3_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOOK && !tlb_valid) |=> !resp_valid && !fill_req);

  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOOK) |-> $onehot0(hit_vec));

  a_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> !resp_miss && resp_data == '0);

  a_r6_fill_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> fill_req && $stable(fill_line));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r10_stray_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_FILL && fill_valid) |=> !(resp_valid && resp_miss));

endmodule

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;
  localparam int PW = 6, NS = 4, LW = 2, DW = 32;
  localparam int IW = 2, WW = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [IW+WW-1:0] req_vwaddr = '0;
  logic tlb_valid = 0, tlb_fault = 0;
  logic [PW-1:0] tlb_ppn = '0;
  logic resp_valid, resp_err, resp_miss;
  logic [DW-1:0] resp_data;
  logic fill_req, fill_valid = 0;
  logic [PW+IW-1:0] fill_line;
  logic [LW*DW-1:0] fill_data = '0;

  vipt_lookup #(.PPN_W(PW), .SETS(NS), .LINE_WORDS(LW), .DW(DW)) u_vipt_lookup (
    .clk, .rst_n, .req_valid, .req_ready, .req_vwaddr, .tlb_valid, .tlb_fault,
    .tlb_ppn, .resp_valid, .resp_err, .resp_miss, .resp_data, .fill_req,
    .fill_line, .fill_valid, .fill_data);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, fills = 0, cycles = 0;
  logic [PW-1:0]    mtag [NS][2];
  logic             mval [NS][2];
  logic             mlru [NS];
  logic [LW*DW-1:0] mline [NS][2];

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [LW*DW-1:0] mkline(input int ppn, input int s, input int n);
    logic [LW*DW-1:0] l;
    for (int w = 0; w < LW; w++)
      l[w*DW +: DW] = 32'hC0DE0000 + (n << 20) + ppn * 256 + s * 16 + w;
    return l;
  endfunction

  task automatic access(input int s, input int w, input int ppn, input int dly, input bit fault);
    int way;
    logic [LW*DW-1:0] l;
    @(negedge clk);
    check("R2 ready when idle", req_ready, 1);
    req_valid = 1;
    req_vwaddr = (IW+WW)'(s * LW + w);
    @(negedge clk);
    req_valid = 0;
    check("R2 busy after accept", req_ready, 0);
    for (int d = 0; d < dly; d++) begin
      check("R3 no response while untranslated", resp_valid, 0);
      check("R3 no fill while untranslated", fill_req, 0);
      @(negedge clk);
    end
    tlb_valid = 1; tlb_fault = fault; tlb_ppn = PW'(ppn);
    @(negedge clk);
    tlb_valid = 0; tlb_fault = 0;
    way = -1;
    for (int k = 0; k < 2; k++) if (mval[s][k] && mtag[s][k] == PW'(ppn)) way = k;
    if (fault) begin
      check("R5 fault resp_valid", resp_valid, 1);
      check("R5 fault resp_err", resp_err, 1);
      check("R5 fault resp_data", resp_data, 0);
      check("R5 fault no fill", fill_req, 0);
    end else if (way >= 0) begin
      check("R4 hit resp_valid", resp_valid, 1);
      check("R4 hit resp_miss", resp_miss, 0);
      check("R4 hit resp_err", resp_err, 0);
      check("R4 hit data", resp_data, mline[s][way][w*DW +: DW]);
      mlru[s] = (way == 0);
    end else begin
      check("R6 miss no resp", resp_valid, 0);
      check("R6 fill_req", fill_req, 1);
      check("R6 fill_line", {24'd0, fill_line}, {24'd0, PW'(ppn), IW'(s)});
      repeat (2) begin
        @(negedge clk);
        check("R6 fill held", fill_req, 1);
        check("R6 fill_line held", {24'd0, fill_line}, {24'd0, PW'(ppn), IW'(s)});
        check("R6 no resp while filling", resp_valid, 0);
      end
      fills++;
      l = mkline(ppn, s, fills);
      fill_valid = 1; fill_data = l;
      @(negedge clk);
      fill_valid = 0;
      check("R7 fill resp_valid", resp_valid, 1);
      check("R7 fill resp_miss", resp_miss, 1);
      check("R7 fill resp_err", resp_err, 0);
      check("R7 fill data", resp_data, l[w*DW +: DW]);
      way = mlru[s];
      mline[s][way] = l; mtag[s][way] = PW'(ppn); mval[s][way] = 1;
      mlru[s] = (way == 0);   // R8 victim from replacement bit
    end
    @(negedge clk);
    check("R9 single response pulse", resp_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mlru[s] = 0;
      for (int k = 0; k < 2; k++) begin mval[s][k] = 0; mtag[s][k] = '0; mline[s][k] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset req_ready", req_ready, 1);
    check("R1 reset resp_valid", resp_valid, 0);
    check("R1 reset fill_req", fill_req, 0);

    tlb_valid = 1; tlb_ppn = 6'd1; fill_valid = 1; fill_data = '1;
    @(negedge clk);
    tlb_valid = 0; fill_valid = 0;
    check("R10 stray inputs no resp", resp_valid, 0);
    check("R10 stray inputs no fill", fill_req, 0);
    check("R10 stray inputs still idle", req_ready, 1);

    for (int s = 0; s < NS; s++) begin
      access(s, 0, s + 1, 0, 0);
      access(s, 1, s + 1, 1, 0);
      access(s, 0, s + 9, 2, 0);
      access(s, 1, s + 1, 0, 1);
      access(s, 0, s + 1, 0, 0);
      access(s, 1, s + 17, 0, 0);
      access(s, 0, s + 9, 1, 0);
      access(s, 1, s + 17, 0, 0);
      access(s, 0, s + 1, 0, 0);
    end
    for (int rep = 0; rep < 3; rep++)
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < LW; w++)
          for (int p = 0; p < 5; p++)
            access(s, w, 30 + ((p * 3 + rep) % 5), (p + rep) % 3, (p + s + rep) % 7 == 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule